// File: doc/BRIEF.md
# Three-Wire Radio Coexistence Arbiter

This block decides, cycle by cycle, whether a best-effort secondary radio may transmit in a 2.4 GHz band that a scheduled mesh radio owns. The secondary radio raises a request line and, in three-wire operation, a priority line. The arbiter answers on a single grant line. The mesh scheduler supplies three inputs: a flag that is high while a mesh time slot runs, a flag that is high while the mesh radio only listens, and the number of ticks left before the next slot. One tick is one clock cycle.

A mesh slot is never pre-empted. Listen-only time can be borrowed only by a high-priority request. A free band is lent to any request. Each grant lasts for a window of at most `MAX_WIN` ticks, and never longer than the ticks left before the next slot. After a window ends, or after a denial, the requester has to drop its request and raise it again. Two saturating counters record how many grants and how many denials have occurred. A mode input selects off, two-wire or three-wire arbitration.

Top module: `coex_arbiter`

## Requirements
- R1: With mode two-wire or three-wire, a request that arrives while both `slot_active_i` and `idle_listen_i` are low, with a nonzero tick count, is granted whatever the priority. `grant_o` rises on the third rising clock edge after `req_i` rises.
- R2: While `slot_active_i` is high, a waiting request is denied, even with `pri_i` high.
- R3: In three-wire mode (`mode_i` = 2'b10 or 2'b11), a high-priority request is granted while `idle_listen_i` is high and `slot_active_i` is low.
- R4: A low-priority request that arrives while `idle_listen_i` is high is denied. If `req_i` then falls and rises again after the mesh radio has gone inactive, the new request is granted.
- R5: A grant stays high for exactly min(`ticks_to_slot_i`, `MAX_WIN`) cycles, with the tick count taken at the decision edge. A tick count of zero is a denial.
- R6: `grant_cnt_o` increases by one for each grant and `deny_cnt_o` increases by one for each denial. Both are zero after reset, both saturate, and they never step in the same cycle.
- R7: When the synchronized request goes low, `grant_o` goes low. A grant withdrawn this way falls on the third rising edge after `req_i` falls.
- R8: After a window expires or a request is denied, no new grant is issued until the request has fallen and risen again.
- R9: In two-wire mode (`mode_i` = 2'b01), the priority line is ignored and every request is treated as low priority.
- R10: In off mode (`mode_i` = 2'b00), `grant_o` is held high, and no grant or denial is counted.
- R11: If `slot_active_i` rises during a grant, `grant_o` falls on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one scheduler tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 off, 01 two-wire, 10 or 11 three-wire |
| req_i | input | 1 | Request from the secondary radio (asynchronous) |
| pri_i | input | 1 | Priority from the secondary radio (asynchronous) |
| slot_active_i | input | 1 | A mesh time slot is in progress |
| idle_listen_i | input | 1 | The mesh radio is only listening |
| ticks_to_slot_i | input | TICK_W | Ticks left before the next mesh slot |
| grant_o | output | 1 | Permission for the secondary radio to transmit |
| grant_cnt_o | output | CNT_W | Saturating count of grants |
| deny_cnt_o | output | CNT_W | Saturating count of denials |

## Verification
The bench counts the exact number of grant cycles for short windows, for tick counts above the cap, and for a tick count of zero. An off-by-one in the window countdown would therefore show up as one cycle too many or too few, and a missing zero check would show up as a spurious one-cycle grant. Because the request is held high after each window, a design that re-grants without a fresh rising edge would produce extra grant cycles. The bench also checks that listen-only time is refused to low priority requests and to all requests in two-wire mode, and that a slot starting in the middle of a grant ends it on the next edge. Finally, it checks that off mode forces the grant high while both counters stay frozen. A design that counted requests made in off mode would show counter values that do not match the expected ones.

// File: rtl/coex_arbiter.sv
module coex_arbiter #(
  parameter int TICK_W  = 8,
  parameter int MAX_WIN = 20,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              req_i,
  input  logic              pri_i,
  input  logic              slot_active_i,
  input  logic              idle_listen_i,
  input  logic [TICK_W-1:0] ticks_to_slot_i,
  output logic              grant_o,
  output logic [CNT_W-1:0]  grant_cnt_o,
  output logic [CNT_W-1:0]  deny_cnt_o
);

  localparam int WIN_W = $clog2(MAX_WIN + 1);
  localparam int CMP_W = (TICK_W > WIN_W) ? TICK_W : WIN_W;
  localparam logic [1:0] MODE_OFF = 2'b00;
  localparam logic [1:0] MODE_2W  = 2'b01;

  typedef enum logic [1:0] {ST_IDLE, ST_GRANT, ST_LOCK} state_t;

  state_t           state;
  logic [WIN_W-1:0] win_cnt;
  logic [1:0]       req_sy, pri_sy;
  logic             req_s, pri_s, off, pri_eff;
  logic             band_free, band_borrow, eligible, take, refuse;
  logic [CMP_W-1:0] ticks_ext, win_len;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_sy <= '0;
      pri_sy <= '0;
    end else begin
      req_sy <= {req_sy[0], req_i};
      pri_sy <= {pri_sy[0], pri_i};
    end

  assign req_s = req_sy[1];
  assign pri_s = pri_sy[1];
  assign off   = (mode_i == MODE_OFF);
  assign pri_eff = pri_s && (mode_i != MODE_2W);

  assign ticks_ext = CMP_W'(ticks_to_slot_i);
  assign win_len   = (ticks_ext > CMP_W'(MAX_WIN)) ? CMP_W'(MAX_WIN) : ticks_ext;

  assign band_free   = !slot_active_i && !idle_listen_i;
  assign band_borrow = !slot_active_i && idle_listen_i && pri_eff;
  assign eligible    = (band_free || band_borrow) && (win_len != '0);
  assign take        = !off && (state == ST_IDLE) && req_s && eligible;
  assign refuse      = !off && (state == ST_IDLE) && req_s && !eligible;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= ST_IDLE;
      win_cnt <= '0;
    end else if (off) begin
      state   <= ST_IDLE;
      win_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE:
          if (take) begin
            state   <= ST_GRANT;
            win_cnt <= WIN_W'(win_len);
          end else if (refuse) begin
            state <= ST_LOCK;
          end
        ST_GRANT:
          if (!req_s) begin
            state   <= ST_IDLE;
            win_cnt <= '0;
          end else if (slot_active_i || win_cnt == WIN_W'(1)) begin
            state   <= ST_LOCK;
            win_cnt <= '0;
          end else begin
            win_cnt <= win_cnt - WIN_W'(1);
          end
        default:
          if (!req_s) state <= ST_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      grant_cnt_o <= '0;
      deny_cnt_o  <= '0;
    end else begin
      if (take && grant_cnt_o != '1)  grant_cnt_o <= grant_cnt_o + CNT_W'(1);
      if (refuse && deny_cnt_o != '1) deny_cnt_o  <= deny_cnt_o + CNT_W'(1);
    end

  assign grant_o = off || (state == ST_GRANT);

  AST_SLOT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!off && slot_active_i) |=> (!grant_o || mode_i == MODE_OFF)); // R2
  AST_REQ_LOW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!off && !req_s) |=> (!grant_o || mode_i == MODE_OFF)); // R7
  AST_WIN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GRANT) |-> (win_cnt != '0 && win_cnt <= WIN_W'(MAX_WIN))); // R5
  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> ($stable(grant_cnt_o) && $stable(deny_cnt_o))); // R10
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !(grant_cnt_o != $past(grant_cnt_o) && deny_cnt_o != $past(deny_cnt_o))); // R6
  AST_TWO_WIRE_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_2W && state == ST_IDLE && idle_listen_i) |=> (state != ST_GRANT)); // R9
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOCK && req_s && !off) |=> (state == ST_LOCK)); // R8

endmodule

// File: tb/test_coex_arbiter.sv
`timescale 1ns/1ps
module test_coex_arbiter;
  localparam int TICK_W = 8;
  localparam int MAX_WIN = 20;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_i = 2'b10;
  logic req_i = 1'b0, pri_i = 1'b0, slot_active_i = 1'b0, idle_listen_i = 1'b0;
  logic [TICK_W-1:0] ticks_to_slot_i = '0;
  logic grant_o;
  logic [CNT_W-1:0] grant_cnt_o, deny_cnt_o;

  int errs = 0, checks = 0, exp_g = 0, exp_d = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  coex_arbiter #(.TICK_W(TICK_W), .MAX_WIN(MAX_WIN), .CNT_W(CNT_W)) i_coex_arbiter (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .req_i(req_i), .pri_i(pri_i),
    .slot_active_i(slot_active_i), .idle_listen_i(idle_listen_i),
    .ticks_to_slot_i(ticks_to_slot_i), .grant_o(grant_o),
    .grant_cnt_o(grant_cnt_o), .deny_cnt_o(deny_cnt_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic release_req();
    req_i = 1'b0;
    cyc(4);
  endtask

  task automatic run_window(input bit pri, input int ticks, input int exp_w, input string tag);
    int highs;
    highs = 0;
    @(negedge clk);
    pri_i = pri;
    ticks_to_slot_i = TICK_W'(ticks);
    req_i = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (grant_o) highs++;
    end
    chk(highs == exp_w, tag, highs, exp_w);
    if (exp_w > 0) exp_g++; else exp_d++;
    release_req();
  endtask

  task automatic t_counters(input string tag);
    chk(grant_cnt_o == CNT_W'(exp_g), {tag, " grants"}, int'(grant_cnt_o), exp_g);
    chk(deny_cnt_o == CNT_W'(exp_d), {tag, " denials"}, int'(deny_cnt_o), exp_d);
  endtask

  task automatic t_reset();
    chk(grant_o == 1'b0, "R6 reset grant", int'(grant_o), 0);
    t_counters("R6 reset");
  endtask

  task automatic t_free_band();
    run_window(1'b0, 10, 10, "R1 free band low priority");
    run_window(1'b1, 10, 10, "R1 free band high priority");
  endtask

  task automatic t_latency();
    @(negedge clk);
    pri_i = 1'b0; ticks_to_slot_i = 8'd10; req_i = 1'b1;
    cyc(2);
    chk(grant_o == 1'b0, "R1 grant before third edge", int'(grant_o), 0);
    cyc(1);
    chk(grant_o == 1'b1, "R1 grant at third edge", int'(grant_o), 1);
    exp_g++;
    release_req();
  endtask

  task automatic t_slot_busy();
    slot_active_i = 1'b1;
    run_window(1'b1, 10, 0, "R2 slot busy high priority");
    slot_active_i = 1'b0;
  endtask

  task automatic t_idle_borrow();
    idle_listen_i = 1'b1;
    run_window(1'b1, 6, 6, "R3 idle listen borrowed");
    run_window(1'b0, 6, 0, "R4 idle listen low priority");
    idle_listen_i = 1'b0;
    run_window(1'b0, 7, 7, "R4 retry after idle ends");
  endtask

  task automatic t_window_bounds();
    run_window(1'b0, 200, MAX_WIN, "R5 window capped");
    run_window(1'b0, 0, 0, "R5 zero ticks denied");
    run_window(1'b0, 1, 1, "R5 one tick window");
  endtask

  task automatic t_req_drop();
    @(negedge clk);
    ticks_to_slot_i = 8'd20; req_i = 1'b1;
    cyc(6);
    chk(grant_o == 1'b1, "R7 grant running", int'(grant_o), 1);
    req_i = 1'b0;
    cyc(2);
    chk(grant_o == 1'b1, "R7 grant before sync delay", int'(grant_o), 1);
    cyc(1);
    chk(grant_o == 1'b0, "R7 grant after request fall", int'(grant_o), 0);
    exp_g++;
    cyc(2);
  endtask

  task automatic t_relock();
    @(negedge clk);
    ticks_to_slot_i = 8'd3; req_i = 1'b1;
    cyc(40);
    chk(grant_o == 1'b0, "R8 no regrant while held", int'(grant_o), 0);
    exp_g++;
    req_i = 1'b0;
    cyc(4);
    req_i = 1'b1;
    cyc(3);
    chk(grant_o == 1'b1, "R8 regrant after toggle", int'(grant_o), 1);
    exp_g++;
    release_req();
  endtask

  task automatic t_two_wire();
    mode_i = 2'b01;
    idle_listen_i = 1'b1;
    run_window(1'b1, 8, 0, "R9 two-wire ignores priority");
    idle_listen_i = 1'b0;
    run_window(1'b1, 8, 8, "R9 two-wire free band");
    mode_i = 2'b10;
  endtask

  task automatic t_mid_slot();
    @(negedge clk);
    ticks_to_slot_i = 8'd20; req_i = 1'b1;
    cyc(5);
    chk(grant_o == 1'b1, "R11 grant before slot", int'(grant_o), 1);
    slot_active_i = 1'b1;
    cyc(1);
    chk(grant_o == 1'b0, "R11 slot withdraws grant", int'(grant_o), 0);
    exp_g++;
    slot_active_i = 1'b0;
    release_req();
  endtask

  task automatic t_off_mode();
    @(negedge clk);
    mode_i = 2'b00;
    slot_active_i = 1'b1;
    #1;
    chk(grant_o == 1'b1, "R10 off forces grant", int'(grant_o), 1);
    req_i = 1'b1;
    cyc(10);
    req_i = 1'b0;
    cyc(4);
    chk(grant_o == 1'b1, "R10 off grant held", int'(grant_o), 1);
    t_counters("R10 off counters frozen");
    slot_active_i = 1'b0;
    mode_i = 2'b10;
    cyc(2);
    chk(grant_o == 1'b0, "R10 leave off mode", int'(grant_o), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errs++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_free_band();
    t_latency();
    t_slot_busy();
    t_idle_borrow();
    t_window_bounds();
    t_counters("R6 mid run");
    t_req_drop();
    t_relock();
    t_two_wire();
    t_mid_slot();
    t_off_mode();
    t_counters("R6 final");
    finish_run();
  end
endmodule